// File: doc/BRIEF.md
# Nested Priority Interrupt Collector

This block merges a set of interrupt request lines (64 by default) into one CPU interrupt output. Every source carries a two-bit priority, an enable and a software request bit. The collector latches requests as pending and selects a winner among the enabled pending sources. It shows the winner's source number and a vector address, which is a programmable table base plus four times that number. A CPU read port exposes all of this through a small 32-bit register bus.

Once the CPU has taken an interrupt, the winner's level becomes in-service. Depending on a control bit, this happens either as a side effect of reading the vector register or through an explicit write to it. With nesting enabled, only a strictly higher level can interrupt a level that is being serviced. With nesting disabled, nothing new is raised until every serviced level has been retired. A service routine retires its level by writing a one-hot mask to the level-acknowledge register. Per-source configuration words, the control word and the base word each have set and clear alias addresses, so single bits can be changed without a read-modify-write.

Top module: `nest_irq_collector`

## Requirements
- R1: After reset, `cpu_irq` is low, the control word (0x020), every configuration word, the base word and the status word read 0, and no level is in service.
- R2: Source n is configured in word 0x060 + (n/4)*0x10, in byte lane (n mod 4)*8. Within its byte, bits 1:0 are the priority, bit 2 is the enable and bit 3 is the software request. The other four bits of each byte read 0.
- R3: The configuration, control (0x020) and base (0x160) words have a set alias at +4 and a clear alias at +8. On these aliases, a written 1 sets or clears that bit and a written 0 leaves it unchanged.
- R4: A source becomes pending one clock after its input line or its software request bit is high. It stays pending until a 1 is written to its bit (n mod 32) in clear word 0x1D0 + (n/32)*0x10, either at that address or at the +4 alias. If a clear and a request occur in the same cycle, the clear wins.
- R5: The winner is the enabled pending source with the highest priority, and the lowest source number wins a tie. The status word (0x030) bits 5:0 read the winner's number, or 0 when there is no candidate.
- R6: The vector word (0x000) reads {base[31:2],2'b00} + 4*winner. The base word stores bits 31:2, and bits 1:0 read 0.
- R7: `cpu_irq` is high only when control bit 16 is 1 and a winner exists that the nesting rule of R9 allows.
- R8: When control bit 18 is 1, a read of 0x000 while `cpu_irq` is high puts the winner's level in service, and a write to 0x000 has no effect on service. When bit 18 is 0, a write to 0x000 while `cpu_irq` is high does this instead, and a read has no effect.
- R9: With control bit 19 at 0, `cpu_irq` needs either no level in service or a winner level strictly above the highest level in service. With bit 19 at 1, it needs no level in service.
- R10: Writing the level-acknowledge word (0x010) clears the in-service flag of every level whose bit (3:0) is 1. `cpu_irq` re-evaluates in the next cycle.
- R11: The raw words 0x040 and 0x050 read input lines 31:0 and 63:32 directly, whatever the enables are.
- R12: The scratch word 0x1F0 reads back the last 32-bit value written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | 64 | Interrupt request lines, active high |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read |
| cpu_irq | output | 1 | Interrupt request to the CPU |

## Verification
The hardest state to reach from the ports is two levels in service at once while a third source competes. Reaching it takes an ordered sequence. First, a low-level source is taken into service. Next, a higher-level source is enabled on top of it. Then the higher source is entered through a vector access and acknowledged while the lower level stays live. The stimulus builds this sequence step by step, turns nesting off midway, and switches the entry mode between read and write. A behavioural model of pending, service and arbitration is compared against `cpu_irq` on every clock, so each intermediate step is checked as well as the final result.

// File: rtl/nic_pkg.sv
package nic_pkg;

  localparam int unsigned NIC_ADDR_W       = 12;
  localparam int unsigned NIC_SRC_PER_WORD = 4;
  localparam int unsigned NIC_LANE_W       = 8;
  localparam int unsigned NIC_LVL_W        = 2;
  localparam int unsigned NIC_NUM_LVL      = 1 << NIC_LVL_W;
  localparam int unsigned NIC_BITS_PER_CLR = 32;

  localparam logic [NIC_ADDR_W-1:0] OFS_VEC  = 12'h000;
  localparam logic [NIC_ADDR_W-1:0] OFS_LACK = 12'h010;
  localparam logic [NIC_ADDR_W-1:0] OFS_CTRL = 12'h020;
  localparam logic [NIC_ADDR_W-1:0] OFS_STAT = 12'h030;
  localparam logic [NIC_ADDR_W-1:0] OFS_RAW0 = 12'h040;
  localparam logic [NIC_ADDR_W-1:0] OFS_CFG0 = 12'h060;
  localparam logic [NIC_ADDR_W-1:0] OFS_BASE = 12'h160;
  localparam logic [NIC_ADDR_W-1:0] OFS_CLR0 = 12'h1D0;
  localparam logic [NIC_ADDR_W-1:0] OFS_SCR  = 12'h1F0;

  localparam int unsigned CTRL_IRQ_EN = 16;
  localparam int unsigned CTRL_RDSVC  = 18;
  localparam int unsigned CTRL_NONEST = 19;

  localparam logic [31:0] CTRL_MASK = (32'h1 << CTRL_IRQ_EN) | (32'h1 << CTRL_RDSVC)
                                    | (32'h1 << CTRL_NONEST);
  localparam logic [31:0] CFG_MASK  = 32'h0F0F_0F0F;
  localparam logic [31:0] BASE_MASK = 32'hFFFF_FFFC;

  typedef logic [NIC_LVL_W-1:0] nic_lvl_t;

  typedef enum logic [1:0] {
    ACC_WRITE = 2'd0,
    ACC_SET   = 2'd1,
    ACC_CLEAR = 2'd2,
    ACC_NONE  = 2'd3
  } nic_acc_e;

  // Access kind from the low nibble of the address: base, +4 set, +8 clear.
  function automatic nic_acc_e nic_decode_acc(input logic [3:0] lo);
    case (lo)
      4'h0:    return ACC_WRITE;
      4'h4:    return ACC_SET;
      4'h8:    return ACC_CLEAR;
      default: return ACC_NONE;
    endcase
  endfunction

  function automatic logic [31:0] nic_apply(input logic [31:0] old_v,
                                            input logic [31:0] wd,
                                            input nic_acc_e acc);
    case (acc)
      ACC_WRITE: return wd;
      ACC_SET:   return old_v | wd;
      ACC_CLEAR: return old_v & ~wd;
      default:   return old_v;
    endcase
  endfunction

endpackage

// File: rtl/nic_src_bank.sv
module nic_src_bank
  import nic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic                                     clk,
  input  logic                                     rst_n,
  input  logic                                     cfg_we,
  input  logic [$clog2(NUM_SRC/NIC_SRC_PER_WORD)-1:0] cfg_widx,
  input  nic_acc_e                                 cfg_acc,
  input  logic [31:0]                              wdata,
  input  logic [$clog2(NUM_SRC/NIC_SRC_PER_WORD)-1:0] cfg_ridx,
  output logic [31:0]                              cfg_rdata,
  input  logic [NUM_SRC-1:0]                       irq_src,
  input  logic                                     clr_we,
  input  logic [((NUM_SRC/NIC_BITS_PER_CLR) > 1 ? $clog2(NUM_SRC/NIC_BITS_PER_CLR) : 1)-1:0] clr_widx,
  output logic [NUM_SRC*NIC_LVL_W-1:0]             src_pri,
  output logic [NUM_SRC-1:0]                       src_en,
  output logic [NUM_SRC-1:0]                       src_pend
);

  localparam int unsigned NUM_WORDS = NUM_SRC / NIC_SRC_PER_WORD;
  localparam int unsigned WIDX_W    = $clog2(NUM_WORDS);
  localparam int unsigned NUM_CLR   = NUM_SRC / NIC_BITS_PER_CLR;
  localparam int unsigned CIDX_W    = (NUM_CLR > 1) ? $clog2(NUM_CLR) : 1;

  logic [NUM_WORDS*32-1:0] cfg_flat;
  logic [NUM_SRC-1:0]      src_sw;
  logic [NUM_SRC-1:0]      pend_d;
  logic [NUM_SRC-1:0]      pend_q;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [31:0] word_q;
    logic [31:0] word_d;
    logic        word_ce;

    assign word_ce = cfg_we && (cfg_widx == WIDX_W'(w));

    always_comb begin
      word_d = word_q;
      if (word_ce) word_d = nic_apply(word_q, wdata, cfg_acc) & CFG_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end

    assign cfg_flat[w*32 +: 32] = word_q;

    for (genvar s = 0; s < NIC_SRC_PER_WORD; s++) begin : g_lane
      localparam int unsigned SN = w*NIC_SRC_PER_WORD + s;
      assign src_pri[SN*NIC_LVL_W +: NIC_LVL_W] = word_q[s*NIC_LANE_W +: NIC_LVL_W];
      assign src_en[SN]                          = word_q[s*NIC_LANE_W + 2];
      assign src_sw[SN]                          = word_q[s*NIC_LANE_W + 3];
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int w = 0; w < int'(NUM_WORDS); w++) begin
      if (cfg_ridx == WIDX_W'(w)) cfg_rdata = cfg_flat[w*32 +: 32];
    end
  end

  // Pending: sticky on request, a clear in the same cycle wins.
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_pend
    logic clr_hit;
    assign clr_hit   = clr_we && (clr_widx == CIDX_W'(n / NIC_BITS_PER_CLR))
                       && wdata[n % NIC_BITS_PER_CLR];
    assign pend_d[n] = clr_hit ? 1'b0 : (pend_q[n] | irq_src[n] | src_sw[n]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign src_pend = pend_q;

endmodule

// File: rtl/nic_arbiter.sv
module nic_arbiter
  import nic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic [NUM_SRC-1:0]           req,
  input  logic [NUM_SRC*NIC_LVL_W-1:0] pri,
  output logic                         win_valid,
  output logic [$clog2(NUM_SRC)-1:0]   win_idx,
  output nic_lvl_t                     win_lvl
);

  localparam int unsigned IDX_W = $clog2(NUM_SRC);

  // Ascending scan with strict compare keeps the lowest index on a tie.
  always_comb begin
    win_valid = 1'b0;
    win_idx   = '0;
    win_lvl   = '0;
    for (int n = 0; n < int'(NUM_SRC); n++) begin
      if (req[n] && (!win_valid || (pri[n*NIC_LVL_W +: NIC_LVL_W] > win_lvl))) begin
        win_valid = 1'b1;
        win_idx   = IDX_W'(n);
        win_lvl   = pri[n*NIC_LVL_W +: NIC_LVL_W];
      end
    end
  end

endmodule

// File: rtl/nic_svc_tracker.sv
module nic_svc_tracker
  import nic_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enter,
  input  logic                   win_valid,
  input  nic_lvl_t               win_lvl,
  input  logic                   ack_we,
  input  logic [NIC_NUM_LVL-1:0] ack_bits,
  input  logic                   no_nest,
  output logic [NIC_NUM_LVL-1:0] in_svc,
  output logic                   allow
);

  logic [NIC_NUM_LVL-1:0] svc_d;
  logic [NIC_NUM_LVL-1:0] svc_q;
  nic_lvl_t               top_lvl;
  logic                   any_svc;

  always_comb begin
    top_lvl = '0;
    for (int l = 0; l < int'(NIC_NUM_LVL); l++) begin
      if (svc_q[l]) top_lvl = nic_lvl_t'(l);
    end
  end

  assign any_svc = |svc_q;

  always_comb begin
    if (no_nest) allow = !any_svc;
    else         allow = !any_svc || (win_valid && (win_lvl > top_lvl));
  end

  // Acknowledge is applied first, then a new entry.
  always_comb begin
    svc_d = svc_q;
    if (ack_we) svc_d = svc_d & ~ack_bits;
    if (enter)  svc_d = svc_d | (NIC_NUM_LVL'(1) << win_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) svc_q <= '0;
    else        svc_q <= svc_d;
  end

  assign in_svc = svc_q;

endmodule

// File: rtl/nest_irq_collector.sv
module nest_irq_collector
  import nic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC-1:0]    irq_src,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [NIC_ADDR_W-1:0] bus_addr,
  input  logic [31:0]           bus_wdata,
  output logic [31:0]           bus_rdata,
  output logic                  cpu_irq
);

  localparam int unsigned NUM_WORDS = NUM_SRC / NIC_SRC_PER_WORD;
  localparam int unsigned WIDX_W    = $clog2(NUM_WORDS);
  localparam int unsigned NUM_CLR   = NUM_SRC / NIC_BITS_PER_CLR;
  localparam int unsigned CIDX_W    = (NUM_CLR > 1) ? $clog2(NUM_CLR) : 1;
  localparam int unsigned IDX_W     = $clog2(NUM_SRC);
  localparam logic [NIC_ADDR_W-1:0] CFG_END = OFS_CFG0 + NIC_ADDR_W'(NUM_WORDS * 16);
  localparam logic [NIC_ADDR_W-1:0] CLR_END = OFS_CLR0 + NIC_ADDR_W'(NUM_CLR * 16);
  localparam logic [NIC_ADDR_W-1:0] RAW_END = OFS_RAW0 + NIC_ADDR_W'(NUM_CLR * 16);

  logic                  wr_op, rd_op;
  nic_acc_e              acc;
  logic [NIC_ADDR_W-1:0] word_addr, cfg_off, clr_off, raw_off;
  logic                  cfg_hit, clr_hit, raw_hit, alias_ok;
  logic [31:0]           ctrl_d, ctrl_q, base_d, base_q, scr_d, scr_q;
  logic                  ctrl_ce, base_ce, scr_ce;
  logic [31:0]           cfg_rdata, raw_word, vec_addr;
  logic [NUM_SRC*NIC_LVL_W-1:0] src_pri;
  logic [NUM_SRC-1:0]    src_en, src_pend;
  logic                  win_valid;
  logic [IDX_W-1:0]      win_idx;
  nic_lvl_t              win_lvl;
  logic [NIC_NUM_LVL-1:0] in_svc;
  logic                  allow, enter, ack_we;

  // ---------------- bus decode ----------------
  assign wr_op     = bus_sel && bus_wr;
  assign rd_op     = bus_sel && !bus_wr;
  assign acc       = nic_decode_acc(bus_addr[3:0]);
  assign alias_ok  = (acc != ACC_NONE);
  assign word_addr = {bus_addr[NIC_ADDR_W-1:4], 4'h0};
  assign cfg_off   = word_addr - OFS_CFG0;
  assign clr_off   = word_addr - OFS_CLR0;
  assign raw_off   = word_addr - OFS_RAW0;
  assign cfg_hit   = (word_addr >= OFS_CFG0) && (word_addr < CFG_END);
  assign clr_hit   = (word_addr >= OFS_CLR0) && (word_addr < CLR_END)
                     && ((acc == ACC_WRITE) || (acc == ACC_SET));
  assign raw_hit   = (word_addr >= OFS_RAW0) && (word_addr < RAW_END) && (bus_addr[3:0] == 4'h0);
  assign ack_we    = wr_op && (bus_addr == OFS_LACK);

  // ---------------- control, base, scratch ----------------
  assign ctrl_ce = wr_op && (word_addr == OFS_CTRL) && alias_ok;
  assign base_ce = wr_op && (word_addr == OFS_BASE) && alias_ok;
  assign scr_ce  = wr_op && (bus_addr == OFS_SCR);

  always_comb begin
    ctrl_d = ctrl_q;
    base_d = base_q;
    scr_d  = scr_q;
    if (ctrl_ce) ctrl_d = nic_apply(ctrl_q, bus_wdata, acc) & CTRL_MASK;
    if (base_ce) base_d = nic_apply(base_q, bus_wdata, acc) & BASE_MASK;
    if (scr_ce)  scr_d  = bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      base_q <= '0;
      scr_q  <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      base_q <= base_d;
      scr_q  <= scr_d;
    end
  end

  // ---------------- sub-blocks ----------------
  nic_src_bank #(.NUM_SRC(NUM_SRC)) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (wr_op && cfg_hit && alias_ok),
    .cfg_widx (WIDX_W'(cfg_off[NIC_ADDR_W-1:4])),
    .cfg_acc  (acc),
    .wdata    (bus_wdata),
    .cfg_ridx (WIDX_W'(cfg_off[NIC_ADDR_W-1:4])),
    .cfg_rdata(cfg_rdata),
    .irq_src  (irq_src),
    .clr_we   (wr_op && clr_hit),
    .clr_widx (CIDX_W'(clr_off[NIC_ADDR_W-1:4])),
    .src_pri  (src_pri),
    .src_en   (src_en),
    .src_pend (src_pend)
  );

  nic_arbiter #(.NUM_SRC(NUM_SRC)) arb_i (
    .req      (src_pend & src_en),
    .pri      (src_pri),
    .win_valid(win_valid),
    .win_idx  (win_idx),
    .win_lvl  (win_lvl)
  );

  assign cpu_irq = ctrl_q[CTRL_IRQ_EN] && win_valid && allow;
  assign enter   = cpu_irq && (bus_addr == OFS_VEC) && (ctrl_q[CTRL_RDSVC] ? rd_op : wr_op);

  nic_svc_tracker svc_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .enter    (enter),
    .win_valid(win_valid),
    .win_lvl  (win_lvl),
    .ack_we   (ack_we),
    .ack_bits (bus_wdata[NIC_NUM_LVL-1:0]),
    .no_nest  (ctrl_q[CTRL_NONEST]),
    .in_svc   (in_svc),
    .allow    (allow)
  );

  // ---------------- read path ----------------
  assign vec_addr = base_q + (32'(win_idx) << 2);

  always_comb begin
    raw_word = '0;
    for (int r = 0; r < int'(NUM_CLR); r++) begin
      if (raw_off[NIC_ADDR_W-1:4] == (NIC_ADDR_W-4)'(r)) raw_word = irq_src[r*32 +: 32];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFS_VEC)         bus_rdata = vec_addr;
    else if (word_addr == OFS_CTRL)  bus_rdata = ctrl_q;
    else if (bus_addr == OFS_STAT)   bus_rdata = 32'(win_idx);
    else if (raw_hit)                bus_rdata = raw_word;
    else if (cfg_hit)                bus_rdata = cfg_rdata;
    else if (word_addr == OFS_BASE)  bus_rdata = base_q;
    else if (bus_addr == OFS_SCR)    bus_rdata = scr_q;
  end

endmodule

// File: rtl/nic_checker.sv
module nic_checker
  import nic_pkg::*;
(
  input logic                   clk,
  input logic                   rst_n,
  input logic                   bus_sel,
  input logic                   bus_wr,
  input logic [NIC_ADDR_W-1:0]  bus_addr,
  input logic [31:0]            bus_wdata,
  input logic                   cpu_irq,
  input logic [31:0]            ctrl_q,
  input logic [NIC_NUM_LVL-1:0] in_svc,
  input logic                   win_valid,
  input nic_lvl_t               win_lvl
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!cpu_irq && ctrl_q == 32'h0 && in_svc == '0));

  // R7
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (ctrl_q[CTRL_IRQ_EN] && win_valid));

  // R8
  read_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr == OFS_VEC && cpu_irq && ctrl_q[CTRL_RDSVC])
    |=> ((in_svc & (NIC_NUM_LVL'(1) << $past(win_lvl))) != '0));

  // R8
  read_no_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !ctrl_q[CTRL_RDSVC]) |=> $stable(in_svc));

  // R8
  idle_svc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |=> $stable(in_svc));

  // R9
  nest_strict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> !in_svc[win_lvl]);

  // R9
  no_nest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && ctrl_q[CTRL_NONEST]) |-> (in_svc == '0));

  // R10
  level_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == OFS_LACK)
    |=> ((in_svc & $past(bus_wdata[NIC_NUM_LVL-1:0])) == '0));

endmodule

bind nest_irq_collector nic_checker chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .cpu_irq  (cpu_irq),
  .ctrl_q   (ctrl_q),
  .in_svc   (in_svc),
  .win_valid(win_valid),
  .win_lvl  (win_lvl)
);

// File: tb/nest_irq_collector_tb_top.sv
module nest_irq_collector_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_src = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cpu_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_on = 1'b0;

  always #2 clk = ~clk;

  nest_irq_collector dut_i (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_irq(cpu_irq)
  );

  // ---------------- behavioural reference ----------------
  int        m_pri [64];
  bit        m_en  [64];
  bit        m_sw  [64];
  bit        m_pend[64];
  bit [3:0]  m_svc;
  bit [31:0] m_ctrl, m_base, m_scr;

  function automatic void m_arb(output bit v, output int idx, output int lvl);
    v = 0; idx = 0; lvl = 0;
    for (int n = 0; n < 64; n++)
      if (m_pend[n] && m_en[n] && (!v || m_pri[n] > lvl)) begin
        v = 1; idx = n; lvl = m_pri[n];
      end
  endfunction

  function automatic bit m_irq();
    bit v; int idx, lvl, top; bit ok;
    m_arb(v, idx, lvl);
    top = -1;
    for (int l = 0; l < 4; l++) if (m_svc[l]) top = l;
    if (m_ctrl[19]) ok = (m_svc == 0);
    else            ok = (top < 0) || (lvl > top);
    return m_ctrl[16] && v && ok;
  endfunction

  function automatic bit [31:0] m_cfg_word(int w);
    bit [31:0] r = 0;
    for (int s = 0; s < 4; s++) begin
      r[s*8 +: 2] = m_pri[w*4+s][1:0];
      r[s*8 + 2]  = m_en[w*4+s];
      r[s*8 + 3]  = m_sw[w*4+s];
    end
    return r;
  endfunction

  function automatic bit [31:0] m_mod(bit [31:0] old_v, bit [31:0] wd, bit [3:0] lo);
    if (lo == 4'h0) return wd;
    if (lo == 4'h4) return old_v | wd;
    if (lo == 4'h8) return old_v & ~wd;
    return old_v;
  endfunction

  function automatic bit [31:0] m_read(bit [11:0] a);
    bit v; int idx, lvl;
    m_arb(v, idx, lvl);
    if (a == 12'h000) return m_base + 32'(idx * 4);
    if (a == 12'h020) return m_ctrl;
    if (a == 12'h030) return 32'(idx);
    if (a == 12'h040) return irq_src[31:0];
    if (a == 12'h050) return irq_src[63:32];
    if (a >= 12'h060 && a < 12'h160) return m_cfg_word((int'(a) - 'h60) / 16);
    if (a == 12'h160) return m_base;
    if (a == 12'h1F0) return m_scr;
    return 0;
  endfunction

  always @(posedge clk) begin : model_p
    bit v; int idx, lvl; bit irq; bit [3:0] lo; bit [11:0] wa; bit [31:0] wv;
    bit nxt[64];
    if (!rst_n) begin
      for (int n = 0; n < 64; n++) begin
        m_pri[n] = 0; m_en[n] = 0; m_sw[n] = 0; m_pend[n] = 0;
      end
      m_svc = 0; m_ctrl = 0; m_base = 0; m_scr = 0;
    end else begin
      m_arb(v, idx, lvl);
      irq = m_irq();
      lo = bus_addr[3:0];
      wa = {bus_addr[11:4], 4'h0};
      for (int n = 0; n < 64; n++) begin
        bit clr;
        clr = bus_sel && bus_wr && (wa == 12'h1D0 + 12'(16 * (n / 32)))
              && (lo == 4'h0 || lo == 4'h4) && bus_wdata[n % 32];
        nxt[n] = clr ? 1'b0 : (m_pend[n] || irq_src[n] || m_sw[n]);
      end
      if (bus_sel && bus_wr && bus_addr == 12'h010) m_svc = m_svc & ~bus_wdata[3:0];
      if (irq && bus_sel && bus_addr == 12'h000 && (m_ctrl[18] ? !bus_wr : bus_wr))
        m_svc[lvl] = 1'b1;
      if (bus_sel && bus_wr && (lo == 4'h0 || lo == 4'h4 || lo == 4'h8)) begin
        if (wa >= 12'h060 && wa < 12'h160) begin
          int w;
          w  = (int'(wa) - 'h60) / 16;
          wv = m_mod(m_cfg_word(w), bus_wdata, lo) & 32'h0F0F0F0F;
          for (int s = 0; s < 4; s++) begin
            m_pri[w*4+s] = int'(wv[s*8 +: 2]);
            m_en[w*4+s]  = wv[s*8 + 2];
            m_sw[w*4+s]  = wv[s*8 + 3];
          end
        end
        if (wa == 12'h020) m_ctrl = m_mod(m_ctrl, bus_wdata, lo) & 32'h000D0000;
        if (wa == 12'h160) m_base = m_mod(m_base, bus_wdata, lo) & 32'hFFFFFFFC;
      end
      if (bus_sel && bus_wr && bus_addr == 12'h1F0) m_scr = bus_wdata;
      for (int n = 0; n < 64; n++) m_pend[n] = nxt[n];
    end
  end

  // ---------------- checking ----------------
  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R7 R9: output compared with the model on every clock
  always @(negedge clk)
    if (mon_on) check("R7/R9 cpu_irq per cycle", {31'b0, cpu_irq}, {31'b0, m_irq()});

  task automatic wr(bit [11:0] a, bit [31:0] d);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(bit [11:0] a, string tag, bit [31:0] exp);
    @(posedge clk); #1;
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    check(tag, bus_rdata, exp);
    check({tag, " model"}, bus_rdata, m_read(a));
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic set_src(bit [63:0] v);
    @(posedge clk); #1;
    irq_src = v;
  endtask

  task automatic irq_is(string tag, bit exp);
    @(negedge clk);
    check(tag, {31'b0, cpu_irq}, {31'b0, exp});
  endtask

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    mon_on = 1'b1;
    // R1
    irq_is("R1 irq after reset", 0);
    rd(12'h020, "R1 ctrl", 32'h0);
    rd(12'h060, "R1 cfg", 32'h0);
    rd(12'h030, "R1 status", 32'h0);
    // R12
    wr(12'h1F0, 32'hA5C3_0F96);
    rd(12'h1F0, "R12 scratch", 32'hA5C3_0F96);
    // R6
    wr(12'h160, 32'h1234_5677);
    rd(12'h160, "R6 base", 32'h1234_5674);
    // R11
    set_src(64'h8000_0001_0000_0020);
    repeat (2) @(posedge clk);
    rd(12'h040, "R11 raw low", 32'h0000_0020);
    rd(12'h050, "R11 raw high", 32'h8000_0001);
    // R2 packing, R3 aliases
    wr(12'h070, 32'hFFFF_FFFF);
    rd(12'h070, "R2 packing", 32'h0F0F_0F0F);
    wr(12'h078, 32'h0C0C_0C0C);
    rd(12'h070, "R3 clear alias", 32'h0303_0303);
    wr(12'h074, 32'h0000_0400);
    rd(12'h070, "R3 set alias", 32'h0303_0703);
    wr(12'h070, 32'h0000_0500);           // source 5: level 1, enabled
    wr(12'h0E0, 32'h0000_0005);           // source 32: level 1, enabled
    wr(12'h024, 32'h0005_0000);           // irq enable + read entry
    rd(12'h020, "R3 ctrl set alias", 32'h0005_0000);
    // R5 tie: 5 and 32 at level 1
    rd(12'h030, "R5 tie lowest index", 32'd5);
    // R8 read entry, R6 vector
    rd(12'h000, "R6 vector src5", 32'h1234_5688);
    irq_is("R8 level 1 entered by read", 0);
    // R9 nesting: level 3 source 63
    wr(12'h150, 32'h0700_0000);
    irq_is("R9 higher level nests", 1);
    rd(12'h030, "R5 highest level", 32'd63);
    rd(12'h000, "R6 vector src63", 32'h1234_5770);
    irq_is("R8 level 3 entered", 0);
    // R10
    wr(12'h010, 32'h8);
    irq_is("R10 ack level 3", 1);
    // R4 clear via +4 alias
    set_src(64'h0000_0001_0000_0020);
    wr(12'h1E4, 32'h8000_0000);
    irq_is("R4 cleared, level 1 still in service", 0);
    rd(12'h030, "R4 winner after clear", 32'd5);
    wr(12'h010, 32'h2);
    irq_is("R10 ack level 1", 1);
    // R9 nesting off
    wr(12'h024, 32'h0008_0000);
    rd(12'h000, "R6 vector src5 again", 32'h1234_5688);
    set_src(64'h8000_0001_0000_0020);
    repeat (2) @(posedge clk);
    irq_is("R9 no nesting blocks higher", 0);
    wr(12'h010, 32'h2);
    irq_is("R9 released after ack", 1);
    // R8 write-entry mode
    wr(12'h028, 32'h0004_0000);
    rd(12'h000, "R8 read without entry", 32'h1234_5770);
    irq_is("R8 read has no effect", 1);
    wr(12'h000, 32'h0);
    irq_is("R8 write enters", 0);
    wr(12'h010, 32'h8);
    irq_is("R10 ack again", 1);
    // R4 software request on source 2 at level 2
    wr(12'h064, 32'h000E_0000);
    wr(12'h158, 32'h0400_0000);
    rd(12'h030, "R4 soft request wins", 32'd2);
    // R7 output disabled
    wr(12'h028, 32'h0001_0000);
    irq_is("R7 disabled output", 0);
    rd(12'h030, "R7 status still valid", 32'd2);
    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule